// File: doc/BRIEF.md
# Streamed Microstore Loader

This block fills a microstore from a stream of bytes that a handshake receiver hands over one per strobe. The stream opens with a 16-bit start address and a 16-bit hunk count. Each of these is sent as two bytes, upper byte first. A hunk is four instructions, which is eight half-words. The loader therefore scales the count by eight and then writes exactly that many half-words.

Each half-word arrives as two input units. The first unit supplies the upper data byte. The second unit supplies the lower data byte plus a 3-bit control code:

- control bit 0 is a 17th data bit that is stored with the half-word;
- control bit 1 picks the left or right half of the instruction;
- control bit 2 asks for the stored parity bit to be deliberately wrong, so that error checking can be exercised.

The write address moves on only after a right half has been written. A left-half write keeps the address, so its partner right half lands at the same location.

When the count runs out, the loader raises a one-cycle done pulse, which tells the sequencer to jump into the loaded code. It then takes two more bytes as a 16-bit checksum. It compares that value with the XOR of every 16-bit word it assembled earlier, and reports a sticky result flag.

Top module: `ustore_loader`

## Requirements
- R1: While reset is held, and immediately after it, wr_en, done, sum_valid and sum_ok are all 0.
- R2: The first two accepted bytes form the start address, first byte in bits 15:8. The first half-word write goes to that address.
- R3: The next two accepted bytes form the hunk count, first byte in bits 15:8. Exactly 8 × count half-word writes follow. done pulses for one cycle, in the same cycle as the last write. A zero count gives done one cycle after the fourth byte is accepted, with no write at all. done never occurs twice.
- R4: For a half-word, the first unit's bits 7:0 become wr_data[15:8]. The second unit's bits 7:0 become wr_data[7:0], and its bit 8 (control bit 0) appears on wr_bit16.
- R5: Bit 9 of the second unit (control bit 1) drives wr_right: 0 selects the left half and 1 selects the right half. The address goes up by one, wrapping modulo 2^16, after each right-half write. It is unchanged after a left-half write.
- R6: When bit 10 of the second unit (control bit 2) is 0, wr_parity makes the 18 bits {wr_parity, wr_bit16, wr_data} hold an odd number of ones. When that bit is 1, wr_parity is the inverse of that value.
- R7: wr_en is high for exactly the one cycle after the second unit of a half-word is accepted, and never at any other time.
- R8: After done, no write occurs. The next two bytes, upper first, are the checksum. One cycle after the second of them, sum_valid rises, and sum_ok is 1 exactly when the checksum equals the XOR of the address word, the count word and every half-word's 16 data bits.
- R9: Input accepted after the checksum has no effect: there is no write, and sum_valid and sum_ok keep their values until reset.
- R10: A cycle with in_valid low has no effect, whatever in_word carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | One-cycle strobe: in_word holds a new unit |
| in_word | input | 11 | Bits 7:0 are the data byte; bits 10:8 are the control code, used only on the second unit of a half-word |
| wr_en | output | 1 | Microstore write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 16 | Half-word data |
| wr_right | output | 1 | 1 selects the right half, 0 the left half |
| wr_bit16 | output | 1 | 17th data bit |
| wr_parity | output | 1 | Parity bit to store |
| done | output | 1 | One-cycle pulse: loading finished, transfer control |
| sum_valid | output | 1 | Checksum has been received |
| sum_ok | output | 1 | Received checksum matched |

## Verification
All outputs are registered, so every result is due in the cycle after the input unit that triggers it is accepted:

- a write, and its address, data, 17th bit, half select and parity;
- the done pulse;
- the checksum flags.

The bench raises in_valid for one cycle at a falling edge. After the rising edge that consumes the unit, it samples at the next falling edge, which is exactly the cycle in which the result must appear. It also checks, at the same sampling point, that the first unit of each pair and every idle cycle leave wr_en low. It sweeps hunk counts 0 to 3, start addresses including the wrap point, and all eight control codes.

// File: rtl/ul_pkg.sv
package ul_pkg;
    typedef enum logic [3:0] {
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_CNT_HI,
        ST_CNT_LO,
        ST_HALF_HI,
        ST_HALF_LO,
        ST_SUM_HI,
        ST_SUM_LO,
        ST_FINISHED
    } ul_state_e;

    localparam int unsigned CTRL_W      = 3;
    localparam int unsigned CTRL_BIT17  = 0;
    localparam int unsigned CTRL_RIGHT  = 1;
    localparam int unsigned CTRL_BADPAR = 2;
endpackage

// File: rtl/ul_parity.sv
module ul_parity #(
    parameter int unsigned W = 17
) (
    input  logic [W-1:0] vec,
    output logic         odd_fill
);
    logic [W:0] chain;
    assign chain[0] = 1'b0;
    generate
        for (genvar i = 0; i < W; i++) begin : g_chain
            assign chain[i+1] = chain[i] ^ vec[i];
        end
    endgenerate
    assign odd_fill = ~chain[W];
endmodule

// File: rtl/ul_xor_accum.sv
module ul_xor_accum #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] word,
    output logic [W-1:0] acc
);
    logic [W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (en) begin
            acc_d = acc_q ^ word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc = acc_q;
endmodule

// File: rtl/ustore_loader.sv
module ustore_loader #(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned HUNK_SHIFT = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [BYTE_W+3-1:0]        in_word,
    output logic                       wr_en,
    output logic [2*BYTE_W-1:0]        wr_addr,
    output logic [2*BYTE_W-1:0]        wr_data,
    output logic                       wr_right,
    output logic                       wr_bit16,
    output logic                       wr_parity,
    output logic                       done,
    output logic                       sum_valid,
    output logic                       sum_ok
);
    import ul_pkg::*;

    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned IN_W   = BYTE_W + CTRL_W;
    localparam int unsigned CNT_W  = WORD_W + HUNK_SHIFT;

    typedef struct packed {
        ul_state_e          st;
        logic [BYTE_W-1:0]  hi;
        logic [WORD_W-1:0]  addr;
        logic [CNT_W-1:0]   cnt;
        logic               wr_en;
        logic [WORD_W-1:0]  wr_addr;
        logic [WORD_W-1:0]  wr_data;
        logic               wr_right;
        logic               wr_bit16;
        logic               wr_parity;
        logic               done;
        logic               sum_valid;
        logic               sum_ok;
    } regs_t;

    regs_t r_d, r_q;

    logic [BYTE_W-1:0] byte_in;
    logic [CTRL_W-1:0] ctrl_in;
    logic [WORD_W-1:0] word_now;
    logic [CNT_W-1:0]  cnt_loaded;
    logic              par_fill;
    logic              acc_en;
    logic [WORD_W-1:0] acc;

    assign byte_in    = in_word[BYTE_W-1:0];
    assign ctrl_in    = in_word[IN_W-1:BYTE_W];
    assign word_now   = {r_q.hi, byte_in};
    assign cnt_loaded = CNT_W'(word_now) << HUNK_SHIFT;

    // Every assembled word before the checksum feeds the running XOR
    assign acc_en = in_valid &&
                    ((r_q.st == ST_ADDR_LO) || (r_q.st == ST_CNT_LO) ||
                     (r_q.st == ST_HALF_LO));

    ul_parity #(.W(WORD_W + 1)) u_par (
        .vec      ({ctrl_in[CTRL_BIT17], word_now}),
        .odd_fill (par_fill)
    );

    ul_xor_accum #(.W(WORD_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (acc_en),
        .word  (word_now),
        .acc   (acc)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        r_d.done  = 1'b0;
        if (in_valid) begin
            unique case (r_q.st)
                ST_ADDR_HI: begin
                    r_d.hi = byte_in;
                    r_d.st = ST_ADDR_LO;
                end
                ST_ADDR_LO: begin
                    r_d.addr = word_now;
                    r_d.st   = ST_CNT_HI;
                end
                ST_CNT_HI: begin
                    r_d.hi = byte_in;
                    r_d.st = ST_CNT_LO;
                end
                ST_CNT_LO: begin
                    r_d.cnt = cnt_loaded;
                    if (word_now == '0) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_SUM_HI;
                    end else begin
                        r_d.st = ST_HALF_HI;
                    end
                end
                ST_HALF_HI: begin
                    r_d.hi = byte_in;
                    r_d.st = ST_HALF_LO;
                end
                ST_HALF_LO: begin
                    r_d.wr_en     = 1'b1;
                    r_d.wr_addr   = r_q.addr;
                    r_d.wr_data   = word_now;
                    r_d.wr_right  = ctrl_in[CTRL_RIGHT];
                    r_d.wr_bit16  = ctrl_in[CTRL_BIT17];
                    r_d.wr_parity = par_fill ^ ctrl_in[CTRL_BADPAR];
                    if (ctrl_in[CTRL_RIGHT]) begin
                        r_d.addr = r_q.addr + 1'b1;
                    end
                    r_d.cnt = r_q.cnt - 1'b1;
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_SUM_HI;
                    end else begin
                        r_d.st = ST_HALF_HI;
                    end
                end
                ST_SUM_HI: begin
                    r_d.hi = byte_in;
                    r_d.st = ST_SUM_LO;
                end
                ST_SUM_LO: begin
                    r_d.sum_valid = 1'b1;
                    r_d.sum_ok    = (word_now == acc);
                    r_d.st        = ST_FINISHED;
                end
                default: begin
                    r_d.st = ST_FINISHED;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_ADDR_HI;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en     = r_q.wr_en;
    assign wr_addr   = r_q.wr_addr;
    assign wr_data   = r_q.wr_data;
    assign wr_right  = r_q.wr_right;
    assign wr_bit16  = r_q.wr_bit16;
    assign wr_parity = r_q.wr_parity;
    assign done      = r_q.done;
    assign sum_valid = r_q.sum_valid;
    assign sum_ok    = r_q.sum_ok;
endmodule

// File: rtl/ustore_loader_chk.sv
module ustore_loader_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_addr,
    input logic              wr_right,
    input logic              done,
    input logic              sum_valid,
    input logic              sum_ok
);
    logic              seen_done;
    logic              have_prev;
    logic              prev_right;
    logic [WORD_W-1:0] prev_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_done  <= 1'b0;
            have_prev  <= 1'b0;
            prev_right <= 1'b0;
            prev_addr  <= '0;
        end else begin
            if (done) begin
                seen_done <= 1'b1;
            end
            if (wr_en) begin
                have_prev  <= 1'b1;
                prev_right <= wr_right;
                prev_addr  <= wr_addr;
            end
        end
    end

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R7
    AST_NO_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_done |-> !wr_en); // R8
    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_done |-> !done); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && have_prev) |-> (wr_addr == (prev_right ? prev_addr + 1'b1 : prev_addr))); // R5
    AST_SUM_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_valid) |-> seen_done); // R8
    AST_SUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |=> (sum_valid && $stable(sum_ok))); // R9
endmodule

bind ustore_loader ustore_loader_chk #(.WORD_W(2 * BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_right  (wr_right),
    .done      (done),
    .sum_valid (sum_valid),
    .sum_ok    (sum_ok)
);

// File: tb/sim_ustore_loader.sv
module sim_ustore_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [10:0] in_word = '0;
    logic        wr_en, wr_right, wr_bit16, wr_parity, done, sum_valid, sum_ok;
    logic [15:0] wr_addr, wr_data;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ustore_loader u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_right(wr_right), .wr_bit16(wr_bit16), .wr_parity(wr_parity),
        .done(done), .sum_valid(sum_valid), .sum_ok(sum_ok)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic [2:0] c);
        @(negedge clk);
        in_word  = {c, b};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 11'h5a5;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!wr_en && !done && !sum_valid && !sum_ok, "R1", "flags in reset",
              {wr_en, done, sum_valid, sum_ok}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_en && !done && !sum_valid && !sum_ok, "R1", "flags after reset",
              {wr_en, done, sum_valid, sum_ok}, 0);
    endtask

    task automatic session(input logic [15:0] start, input logic [15:0] hunks,
                           input int seed, input bit corrupt);
        logic [15:0] exp_sum, ea, s;
        int n;
        do_reset();
        exp_sum = start ^ hunks;
        send(start[15:8], 3'b000);
        check(!wr_en, "R7", "no write on address byte", wr_en, 0);
        if (seed[0]) begin
            // R10: idle cycles with garbage on in_word
            in_word = 11'h7ff;
            repeat (3) @(negedge clk);
            check(!wr_en && !done, "R10", "idle cycles inert", {wr_en, done}, 0);
        end
        send(start[7:0], 3'b000);
        send(hunks[15:8], 3'b000);
        send(hunks[7:0], 3'b000);
        check(done == (hunks == 0), "R3", "done after count", done, hunks == 0);
        check(!wr_en, "R3", "no write on count", wr_en, 0);
        ea = start;
        n  = int'(hunks) * 8;
        for (int k = 0; k < n; k++) begin
            logic [7:0] h, l;
            logic [2:0] c;
            logic       ep;
            h = 8'((k * 37 + seed * 11 + 3) & 8'hff);
            l = 8'((k * 91 + seed * 5) & 8'hff);
            c = 3'((k + seed * 3) % 8);
            send(h, 3'b111);
            check(!wr_en, "R7", "no write on first unit", wr_en, 0);
            if (seed[0] && k == 1) begin
                in_word = 11'h3c3;
                repeat (2) @(negedge clk);
                check(!wr_en, "R10", "idle inside pair", wr_en, 0);
            end
            send(l, c);
            ep = (($countones({c[0], h, l}) % 2) == 0) ? 1'b1 : 1'b0;
            ep = ep ^ c[2];
            check(wr_en, "R7", "write strobe", wr_en, 1);
            check(wr_addr == ea, (k == 0) ? "R2" : "R5", "address", wr_addr, ea);
            check(wr_data == {h, l}, "R4", "data", wr_data, {h, l});
            check(wr_bit16 == c[0], "R4", "bit16", wr_bit16, c[0]);
            check(wr_right == c[1], "R5", "half select", wr_right, c[1]);
            check(wr_parity == ep, "R6", "parity", wr_parity, ep);
            check(done == (k == n - 1), "R3", "done timing", done, k == n - 1);
            exp_sum = exp_sum ^ {h, l};
            if (c[1]) ea = ea + 16'd1;
        end
        s = corrupt ? (exp_sum ^ 16'h0100) : exp_sum;
        send(s[15:8], 3'b010);
        check(!wr_en && !sum_valid && !done, "R8", "no write after done",
              {wr_en, sum_valid, done}, 0);
        send(s[7:0], 3'b010);
        check(sum_valid, "R8", "sum_valid", sum_valid, 1);
        check(sum_ok == !corrupt, "R8", "sum_ok", sum_ok, !corrupt);
        check(!wr_en, "R8", "no write on checksum", wr_en, 0);
        send(8'hee, 3'b111);
        send(8'h11, 3'b010);
        check(!wr_en && sum_valid && (sum_ok == !corrupt) && !done, "R9",
              "extra input ignored", {wr_en, sum_valid, sum_ok, done},
              {3'b010, !corrupt, 1'b0});
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        session(16'h0123, 16'd1, 0, 1'b0);
        session(16'hffff, 16'd2, 1, 1'b0);
        session(16'h8000, 16'd0, 2, 1'b0);
        session(16'h00ff, 16'd3, 3, 1'b1);
        session(16'h4a5c, 16'd0, 5, 1'b1);
        for (int hc = 0; hc < 4; hc++) begin
            for (int sd = 0; sd < 4; sd++) begin
                session(16'((hc * 16'h1357 + sd * 16'h0f0f) & 16'hffff),
                        16'(hc), sd + 6, sd[1]);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule